// File: doc/BRIEF.md
# RF Level-Present Detector

This block decides whether reflected light is reaching the pickup, using a digitized RF stream. Each valid sample is a signed value measured from the mid-reference. Negative values count as zero. A peak-hold stage keeps the largest positive level it has seen, and lets that level sink slowly when no larger sample arrives. The held level is compared with a programmable threshold that has programmable hysteresis, which produces a fast presence flag.

The decision rests on the DC envelope and not on pit modulation. A steady, unmodulated level therefore keeps the flag raised. This is what allows the focus loop to close on a bare mirror band, and it keeps the flag high during playback.

A second flag is meant for a supervising controller. It comes from a saturating up/down counter that steps once per valid sample. The counter rises while the fast flag is high and falls while it is low. The second flag raises at an upper trip point and drops at a lower one, so short dropouts are ignored. The controller uses this filtered flag for protection and gain decisions.

Top module: `rflvl_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the held level, the fast flag and the filtered flag to zero. After reset, a below-threshold sample leaves the fast flag low.
- R2: A valid sample loads the held level only when it is strictly greater than the held level. A sample with its sign bit set is treated as zero and never raises the held level.
- R3: The fast flag `rf_ok` goes high, two clocks after the strobe, once the held level is at or above `thr_level`. It stays high under a constant, unmodulated input level.
- R4: Once high, `rf_ok` drops only when the held level falls below `thr_level - thr_hyst`, where that difference is floored at zero. While `rf_ok` is low, a held level between that floor and `thr_level` keeps it low.
- R5: Valid samples that do not load count toward a decay step. When `decay_period + 1` of them have arrived since the last load or step, the held level loses `held >> decay_shift`. Clocks with no strobe leave the held level untouched.
- R6: When the shifted decay amount is zero but the held level is not, the step is one, so the level always reaches zero.
- R7: The filter counter changes only on valid samples, by one at a time, and saturates at 0 and at `CNT_MAX` without wrapping.
- R8: `rf_ok_filt` raises when the counter is at or above `HI_TRIP`, drops when it is at or below `LO_TRIP`, and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed RF sample relative to mid-reference |
| thr_level | input | SAMPLE_W-1 | Set threshold on the held level |
| thr_hyst | input | SAMPLE_W-1 | Hysteresis below the set threshold |
| decay_shift | input | SHIFT_W | Right-shift that sizes each decay step |
| decay_period | input | DIV_W | Non-loading samples per decay step, minus one |
| rf_ok | output | 1 | Fast level-present flag |
| rf_ok_filt | output | 1 | Debounced level-present flag |

## Verification
The hardest case to reach is the filter counter's saturation and its middle band. This needs many more strobes than the counter has states, with the fast flag held steady, followed by a reversal whose effect lags the flag. The stimulus holds a constant above-threshold level for more samples than the counter width can hold, which would expose a wrap. It then forces the held level to zero in one step, using a zero decay shift, and sends negative samples. It checks the filtered flag before the counter crosses the lower trip point and again after. The decay steps are placed precisely by setting the decay shift so that a single step carries the level across the lower trip point.

// File: rtl/rflvl_pkg.sv
`timescale 1ns/1ps
package rflvl_pkg;
   typedef enum logic {
      LVL_LOST    = 1'b0,
      LVL_PRESENT = 1'b1
   } lvl_state_e;
endpackage

// File: rtl/rflvl_peak_hold.sv
`timescale 1ns/1ps
module rflvl_peak_hold #(
   parameter int SAMPLE_W = 12,
   parameter int SHIFT_W  = 3,
   parameter int DIV_W    = 8,
   localparam int MAG_W   = SAMPLE_W - 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_vld,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic [SHIFT_W-1:0]         decay_shift,
   input  logic [DIV_W-1:0]           decay_period,
   output logic [MAG_W-1:0]           held
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("rflvl_peak_hold: SAMPLE_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("rflvl_peak_hold: DIV_W must be at least 1");
      end
   endgenerate

   logic [MAG_W-1:0] held_q;
   logic [MAG_W-1:0] pos_mag;
   logic [MAG_W-1:0] shifted;
   logic [MAG_W-1:0] step;
   logic [DIV_W-1:0] dcnt_q;

   assign pos_mag = smp_data[SAMPLE_W-1] ? '0 : smp_data[MAG_W-1:0];
   assign shifted = held_q >> decay_shift;
   assign step    = (|shifted) ? shifted : {{(MAG_W-1){1'b0}}, |held_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= '0;
         dcnt_q <= '0;
      end else if (smp_vld) begin
         if (pos_mag > held_q) begin
            held_q <= pos_mag;
            dcnt_q <= '0;
         end else if (dcnt_q >= decay_period) begin
            held_q <= held_q - step;
            dcnt_q <= '0;
         end else begin
            dcnt_q <= dcnt_q + 1'b1;
         end
      end
   end

   assign held = held_q;
endmodule

// File: rtl/rflvl_hyst_cmp.sv
`timescale 1ns/1ps
module rflvl_hyst_cmp
   import rflvl_pkg::*;
#(
   parameter int MAG_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [MAG_W-1:0] held,
   input  logic [MAG_W-1:0] thr_level,
   input  logic [MAG_W-1:0] thr_hyst,
   output logic             present
);
   lvl_state_e       state_q;
   logic [MAG_W-1:0] lo_trip;

   assign lo_trip = (thr_hyst > thr_level) ? '0 : thr_level - thr_hyst;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= LVL_LOST;
      end else if (held >= thr_level) begin
         state_q <= LVL_PRESENT;
      end else if (held < lo_trip) begin
         state_q <= LVL_LOST;
      end
   end

   assign present = (state_q == LVL_PRESENT);
endmodule

// File: rtl/rflvl_debounce.sv
`timescale 1ns/1ps
module rflvl_debounce #(
   parameter int CNT_MAX = 63,
   parameter int HI_TRIP = 48,
   parameter int LO_TRIP = 16,
   localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic             lvl_in,
   output logic             flag,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (CNT_MAX < 2) begin : g_bad_max
         $error("rflvl_debounce: CNT_MAX must be at least 2");
      end
      if (LO_TRIP >= HI_TRIP) begin : g_bad_order
         $error("rflvl_debounce: LO_TRIP must be below HI_TRIP");
      end
      if (HI_TRIP > CNT_MAX) begin : g_bad_hi
         $error("rflvl_debounce: HI_TRIP must not exceed CNT_MAX");
      end
   endgenerate

   localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] HI  = CNT_W'(HI_TRIP);
   localparam logic [CNT_W-1:0] LO  = CNT_W'(LO_TRIP);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (step_en) begin
         if (lvl_in && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (!lvl_in && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
      end else if (cnt_q >= HI) begin
         flag_q <= 1'b1;
      end else if (cnt_q <= LO) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign cnt  = cnt_q;
endmodule

// File: rtl/rflvl_detect.sv
`timescale 1ns/1ps
module rflvl_detect #(
   parameter int SAMPLE_W = 12,
   parameter int SHIFT_W  = 3,
   parameter int DIV_W    = 8,
   parameter int CNT_MAX  = 63,
   parameter int HI_TRIP  = 48,
   parameter int LO_TRIP  = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_vld,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-2:0]        thr_level,
   input  logic [SAMPLE_W-2:0]        thr_hyst,
   input  logic [SHIFT_W-1:0]         decay_shift,
   input  logic [DIV_W-1:0]           decay_period,
   output logic                       rf_ok,
   output logic                       rf_ok_filt
);
   localparam int MAG_W = SAMPLE_W - 1;
   localparam int CNT_W = $clog2(CNT_MAX + 1);

   logic [MAG_W-1:0] held_lvl;
   logic [CNT_W-1:0] dbc_cnt;
   logic             ok_fast;

   rflvl_peak_hold #(
      .SAMPLE_W (SAMPLE_W),
      .SHIFT_W  (SHIFT_W),
      .DIV_W    (DIV_W)
   ) u_peak (
      .clk          (clk),
      .rst          (rst),
      .smp_vld      (smp_vld),
      .smp_data     (smp_data),
      .decay_shift  (decay_shift),
      .decay_period (decay_period),
      .held         (held_lvl)
   );

   rflvl_hyst_cmp #(
      .MAG_W (MAG_W)
   ) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .held      (held_lvl),
      .thr_level (thr_level),
      .thr_hyst  (thr_hyst),
      .present   (ok_fast)
   );

   rflvl_debounce #(
      .CNT_MAX (CNT_MAX),
      .HI_TRIP (HI_TRIP),
      .LO_TRIP (LO_TRIP)
   ) u_dbc (
      .clk     (clk),
      .rst     (rst),
      .step_en (smp_vld),
      .lvl_in  (ok_fast),
      .flag    (rf_ok_filt),
      .cnt     (dbc_cnt)
   );

   assign rf_ok = ok_fast;
endmodule

// File: rtl/rflvl_detect_chk.sv
`timescale 1ns/1ps
module rflvl_detect_chk #(
   parameter int SAMPLE_W = 12,
   parameter int CNT_MAX  = 63,
   parameter int HI_TRIP  = 48,
   parameter int LO_TRIP  = 16,
   localparam int MAG_W   = SAMPLE_W - 1,
   localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       smp_vld,
   input logic signed [SAMPLE_W-1:0] smp_data,
   input logic [MAG_W-1:0]           thr_level,
   input logic [MAG_W-1:0]           thr_hyst,
   input logic                       rf_ok,
   input logic                       rf_ok_filt,
   input logic [MAG_W-1:0]           held,
   input logic [CNT_W-1:0]           cnt
);
   logic [MAG_W-1:0] pos_c;
   assign pos_c = smp_data[SAMPLE_W-1] ? '0 : smp_data[MAG_W-1:0];

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!rf_ok && !rf_ok_filt && held == '0 && cnt == '0)); // R1

   AST_PEAK_LOAD: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && pos_c > held) |=> (held == $past(pos_c))); // R2

   AST_NEG_NO_RISE: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && smp_data[SAMPLE_W-1]) |=> (held <= $past(held))); // R2

   AST_SET_ON_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (held >= thr_level) |=> rf_ok); // R3

   AST_DROP_BELOW_BAND: assert property (@(posedge clk) disable iff (rst)
      $fell(rf_ok) |-> (({1'b0, $past(held)} + {1'b0, $past(thr_hyst)}) < {1'b0, $past(thr_level)})); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(held)); // R5

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(CNT_MAX)); // R7

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> $stable(cnt)); // R7

   AST_FILT_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(rf_ok_filt) |-> ($past(cnt) >= CNT_W'(HI_TRIP))); // R8

   AST_FILT_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(rf_ok_filt) |-> ($past(cnt) <= CNT_W'(LO_TRIP))); // R8
endmodule

bind rflvl_detect rflvl_detect_chk #(
   .SAMPLE_W (SAMPLE_W),
   .CNT_MAX  (CNT_MAX),
   .HI_TRIP  (HI_TRIP),
   .LO_TRIP  (LO_TRIP)
) i_rflvl_chk (
   .clk        (clk),
   .rst        (rst),
   .smp_vld    (smp_vld),
   .smp_data   (smp_data),
   .thr_level  (thr_level),
   .thr_hyst   (thr_hyst),
   .rf_ok      (rf_ok),
   .rf_ok_filt (rf_ok_filt),
   .held       (held_lvl),
   .cnt        (dbc_cnt)
);

// File: tb/test_rflvl_detect.sv
`timescale 1ns/1ps
module test_rflvl_detect;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              smp_vld = 1'b0;
   logic signed [11:0] smp_data = '0;
   logic [10:0]       thr_level = 11'd400;
   logic [10:0]       thr_hyst = 11'd100;
   logic [2:0]        decay_shift = 3'd7;
   logic [7:0]        decay_period = 8'd255;
   logic              rf_ok;
   logic              rf_ok_filt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rflvl_detect i_rflvl_detect (
      .clk          (clk),
      .rst          (rst),
      .smp_vld      (smp_vld),
      .smp_data     (smp_data),
      .thr_level    (thr_level),
      .thr_hyst     (thr_hyst),
      .decay_shift  (decay_shift),
      .decay_period (decay_period),
      .rf_ok        (rf_ok),
      .rf_ok_filt   (rf_ok_filt)
   );

   // {sample, expected rf_ok}; threshold 400, hysteresis 100, negligible decay
   localparam logic [12:0] VEC [0:6] = '{
      {12'h000, 1'b0},   // R3 zero level
      {12'hCE0, 1'b0},   // R2 -800 counts as zero
      {12'h18F, 1'b0},   // R3 399 just below
      {12'h190, 1'b1},   // R3 400 at threshold
      {12'h064, 1'b1},   // R2 smaller sample ignored
      {12'h800, 1'b1},   // R2 most negative ignored
      {12'h7FF, 1'b1}    // R2 largest positive
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic send(input logic signed [11:0] s);
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_data = s;
      @(negedge clk);
      smp_vld  = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset rf_ok", rf_ok, 1'b0);
      check("R1 reset rf_ok_filt", rf_ok_filt, 1'b0);

      for (int i = 0; i < 7; i++) begin
         send(VEC[i][12:1]);
         check("R2/R3 vector", rf_ok, VEC[i][0]);
      end

      // hysteresis band, shift 3 every sample: 400 -> 350 -> 307 -> 269
      do_reset();
      decay_period = 8'd0;
      decay_shift  = 3'd3;
      send(12'sd400);
      check("R3 set at 400", rf_ok, 1'b1);
      send(12'sd0);
      check("R4 held 350 stays", rf_ok, 1'b1);
      send(12'sd0);
      check("R4 held 307 stays", rf_ok, 1'b1);
      send(12'sd0);
      check("R4 held 269 drops", rf_ok, 1'b0);
      send(12'sd350);
      check("R4 350 inside band stays low", rf_ok, 1'b0);
      send(12'sd400);
      check("R3 re-set at 400", rf_ok, 1'b1);

      // decay every 4th non-loading sample, shift 1: 400 -> 200
      do_reset();
      decay_period = 8'd3;
      decay_shift  = 3'd1;
      send(12'sd400);
      for (int i = 0; i < 3; i++) send(12'sd0);
      check("R5 no step before period", rf_ok, 1'b1);
      send(12'sd0);
      check("R5 step after period", rf_ok, 1'b0);

      // minimum step of one: 3 -> 2 -> 1 -> 0 with threshold 1
      do_reset();
      thr_level    = 11'd1;
      thr_hyst     = 11'd0;
      decay_period = 8'd0;
      decay_shift  = 3'd7;
      send(12'sd3);
      check("R6 set at 3", rf_ok, 1'b1);
      send(12'sd0);
      send(12'sd0);
      check("R6 held 1 stays", rf_ok, 1'b1);
      send(12'sd0);
      check("R6 reaches zero", rf_ok, 1'b0);

      // reset in mid-run clears the held level
      thr_level    = 11'd400;
      thr_hyst     = 11'd100;
      decay_period = 8'd255;
      send(12'sd500);
      check("R3 set at 500", rf_ok, 1'b1);
      do_reset();
      check("R1 mid reset rf_ok", rf_ok, 1'b0);
      check("R1 mid reset filt", rf_ok_filt, 1'b0);
      send(12'sd0);
      check("R1 held cleared", rf_ok, 1'b0);

      // filter: ramp, saturation past counter width, middle band, release
      do_reset();
      for (int i = 0; i < 30; i++) send(12'sd500);
      check("R8 below upper trip", rf_ok_filt, 1'b0);
      for (int i = 0; i < 70; i++) send(12'sd500);
      check("R3 constant level keeps flag", rf_ok, 1'b1);
      check("R7 saturates without wrap", rf_ok_filt, 1'b1);
      decay_period = 8'd0;
      decay_shift  = 3'd0;
      send(-12'sd100);
      check("R5 shift 0 empties held", rf_ok, 1'b0);
      for (int i = 0; i < 20; i++) send(-12'sd100);
      check("R8 middle band holds high", rf_ok_filt, 1'b1);
      for (int i = 0; i < 40; i++) send(-12'sd100);
      check("R8 drops at lower trip", rf_ok_filt, 1'b0);
      check("R2 negatives keep level low", rf_ok, 1'b0);

      done = 1'b1;
      finish_run();
   end
endmodule